// File: doc/BRIEF.md
# Console Serial Port Register Block

This block sits on a simple synchronous register bus and gives software a console serial port: two control/status registers (one for the receive side, one for the transmit side), a receive data register, a transmit data register and a fixed identification word. On the character side it takes a byte from a receive source together with a "character waiting" level, and it consumes that byte with a one-cycle pop strobe. A write to the transmit data register sends a byte out with a one-cycle valid strobe. Bit-level serial framing and baud timing belong to the logic on either side of it.

A single interrupt line is shared by both directions. The interrupt conditions are checked every clock cycle. The transmitter never pushes back, so its ready flag is always set. This means that once the transmit interrupt is enabled, it keeps firing until software disables it. Each time the line is asserted, a vector byte is captured that names the cause. The line is sticky: only a write to one of the two status registers lowers it.

Top module: `console_serial_ctrl`

## Requirements
- R1: After reset the interrupt line, vector byte, read data, read-valid, pop strobe and transmit strobe are all 0, and both control fields are 0.
- R2: A read of the receive status register (offset 0x80) returns bit 7 equal to the live character-waiting input and bits 6:0 equal to the stored receive control field. The upper bits are 0. Read data and read-valid appear one cycle after the access.
- R3: A read of the transmit status register (offset 0x88) always returns bit 7 as 1 and bits 6:0 as the stored transmit control field.
- R4: A write to either status register loads bits 6:0 from the written data. The value written to bit 7 is discarded.
- R5: A read of receive data (offset 0x84) returns the waiting byte and raises the pop strobe for exactly one cycle when a character is waiting. When no character is waiting, it returns 0 and does not pop.
- R6: A write to transmit data (offset 0x8C) presents the low byte of the write data on the transmit byte output with the valid strobe high for exactly the next cycle. A read of that offset returns 0.
- R7: Offset 0x100 reads as 128. Any other offset reads as 0, and writes to it change no output or stored field.
- R8: When the receive enable (control bit 6) is set and a character is waiting, the interrupt is asserted on the next clock edge with vector 0xF8.
- R9: When the transmit enable (control bit 6) is set, the interrupt is asserted on the next clock edge with vector 0xFC. If both conditions hold, the transmit vector 0xFC wins.
- R10: A write to either status register lowers the interrupt at that clock edge. If no status register is written, the line stays asserted even after its cause goes away.
- R11: Writes to the receive data offset are ignored: no pop, no transmit strobe, and no change to the interrupt or the control fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| rx_avail | input | 1 | A received character is waiting |
| rx_byte | input | 8 | The waiting character |
| rx_pop | output | 1 | Consume the waiting character |
| tx_byte | output | 8 | Byte to transmit |
| tx_valid | output | 1 | tx_byte is valid this cycle |
| irq | output | 1 | Interrupt request |
| irq_vector | output | 8 | Cause of the last assertion |

## Verification
The hardest case to reach is one where both interrupt causes hold at once and the status write that clears the line arrives in the same cycle as a fresh cause. The bench first enables the transmit interrupt. It then holds a character waiting and writes the receive enable. It checks that the line drops at the write edge and comes back one edge later with the transmit vector. Next it removes the transmit enable and checks that the receive vector takes its place. Stickiness is exercised by taking away the waiting character while the line is up.

// File: rtl/cons_pkg.sv
package cons_pkg;
  localparam int unsigned OFS_RX_STAT = 'h080;
  localparam int unsigned OFS_RX_DATA = 'h084;
  localparam int unsigned OFS_TX_STAT = 'h088;
  localparam int unsigned OFS_TX_DATA = 'h08C;
  localparam int unsigned OFS_IDENT   = 'h100;

  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned CTL_W    = FLAG_BIT;

  localparam logic [7:0] VEC_RX   = 8'hF8;
  localparam logic [7:0] VEC_TX   = 8'hFC;
  localparam int unsigned IDENT_VALUE = 128;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_STAT,
    SEL_RX_DATA,
    SEL_TX_STAT,
    SEL_TX_DATA,
    SEL_IDENT
  } reg_sel_e;
endpackage

// File: rtl/cs_decode.sv
module cs_decode
  import cons_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_RX_STAT))      sel = SEL_RX_STAT;
    else if (addr == ADDR_W'(OFS_RX_DATA)) sel = SEL_RX_DATA;
    else if (addr == ADDR_W'(OFS_TX_STAT)) sel = SEL_TX_STAT;
    else if (addr == ADDR_W'(OFS_TX_DATA)) sel = SEL_TX_DATA;
    else if (addr == ADDR_W'(OFS_IDENT))   sel = SEL_IDENT;
    else                                   sel = SEL_NONE;
  end
endmodule

// File: rtl/cs_regs.sv
module cs_regs
  import cons_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  reg_sel_e          sel,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              rx_avail,
  input  logic [7:0]        rx_byte,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              rx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  output logic              rx_ie,
  output logic              tx_ie,
  output logic              status_wr
);
  localparam int unsigned NCH = 2;
  localparam int unsigned CH_RX = 0;
  localparam int unsigned CH_TX = 1;

  logic [NCH-1:0]            ctl_wr;
  logic [NCH-1:0][CTL_W-1:0] ctl_q;
  logic                      rd_en;
  logic                      tx_wr;
  logic [DATA_W-1:0]         rd_mux;

  assign rd_en         = bus_en && !bus_we;
  assign tx_wr         = bus_en && bus_we && (sel == SEL_TX_DATA);
  assign ctl_wr[CH_RX] = bus_en && bus_we && (sel == SEL_RX_STAT);
  assign ctl_wr[CH_TX] = bus_en && bus_we && (sel == SEL_TX_STAT);
  assign status_wr     = |ctl_wr;
  assign rx_ie         = ctl_q[CH_RX][IE_BIT];
  assign tx_ie         = ctl_q[CH_TX][IE_BIT];

  // control fields; the flag bit is never stored
  always_ff @(posedge clk) begin
    for (int ch = 0; ch < NCH; ch++) begin
      if (rst) ctl_q[ch] <= '0;
      else if (ctl_wr[ch]) ctl_q[ch] <= bus_wdata[CTL_W-1:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_RX_STAT: rd_mux = DATA_W'({rx_avail, ctl_q[CH_RX]});
      SEL_RX_DATA: rd_mux = rx_avail ? DATA_W'(rx_byte) : '0;
      SEL_TX_STAT: rd_mux = DATA_W'({1'b1, ctl_q[CH_TX]});
      SEL_IDENT:   rd_mux = DATA_W'(IDENT_VALUE);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rvalid   <= 1'b0;
      rx_pop   <= 1'b0;
      tx_byte  <= '0;
      tx_valid <= 1'b0;
    end else begin
      rvalid   <= rd_en;
      rx_pop   <= rd_en && (sel == SEL_RX_DATA) && rx_avail;
      tx_valid <= tx_wr;
      if (rd_en) rdata   <= rd_mux;
      if (tx_wr) tx_byte <= bus_wdata[7:0];
    end
  end

  assert_pop_after_avail_R5: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(rx_avail) && $past(bus_en) && !$past(bus_we));
  assert_pop_single_R5: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !rx_pop || $past(bus_en));
  assert_tx_from_write_R6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_en) && $past(bus_we));
  assert_rvalid_from_read_R2: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(bus_en) && !$past(bus_we));
endmodule

// File: rtl/cs_irq.sv
module cs_irq
  import cons_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_ie,
  input  logic       tx_ie,
  input  logic       rx_avail,
  input  logic       status_wr,
  output logic       irq,
  output logic [7:0] irq_vector
);
  logic rx_fire;
  assign rx_fire = rx_ie && rx_avail;

  // clear has priority; transmit cause overrides receive
  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      irq_vector <= '0;
    end else if (status_wr) begin
      irq <= 1'b0;
    end else if (tx_ie) begin
      irq        <= 1'b1;
      irq_vector <= VEC_TX;
    end else if (rx_fire) begin
      irq        <= 1'b1;
      irq_vector <= VEC_RX;
    end
  end

  assert_clear_on_status_R10: assert property (@(posedge clk) disable iff (rst)
    $past(status_wr) |-> !irq);
  assert_tx_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(tx_ie) && !$past(status_wr)) |-> irq && irq_vector == VEC_TX);
  assert_rx_cause_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_ie) && $past(rx_avail) && !$past(tx_ie) && !$past(status_wr))
      |-> irq && irq_vector == VEC_RX);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && !status_wr) |=> irq);
  assert_vector_legal_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_vector == VEC_RX || irq_vector == VEC_TX));
endmodule

// File: rtl/console_serial_ctrl.sv
module console_serial_ctrl
  import cons_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              rx_avail,
  input  logic [7:0]        rx_byte,
  output logic              rx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  output logic              irq,
  output logic [7:0]        irq_vector
);
  reg_sel_e sel;
  logic     rx_ie;
  logic     tx_ie;
  logic     status_wr;

  cs_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  cs_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .rx_avail  (rx_avail),
    .rx_byte   (rx_byte),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid),
    .rx_pop    (rx_pop),
    .tx_byte   (tx_byte),
    .tx_valid  (tx_valid),
    .rx_ie     (rx_ie),
    .tx_ie     (tx_ie),
    .status_wr (status_wr)
  );

  cs_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .rx_ie      (rx_ie),
    .tx_ie      (tx_ie),
    .rx_avail   (rx_avail),
    .status_wr  (status_wr),
    .irq        (irq),
    .irq_vector (irq_vector)
  );
endmodule

// File: tb/sim_console_serial_ctrl.sv
`timescale 1ns/1ps
module sim_console_serial_ctrl;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_en = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_rvalid;
  logic              rx_avail = 1'b0;
  logic [7:0]        rx_byte = '0;
  logic              rx_pop;
  logic [7:0]        tx_byte;
  logic              tx_valid;
  logic              irq;
  logic [7:0]        irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DATA_W-1:0] exp_q [$];
  string             tag_q [$];

  always #2 clk = ~clk;

  console_serial_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rx_avail(rx_avail), .rx_byte(rx_byte),
    .rx_pop(rx_pop), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .irq(irq), .irq_vector(irq_vector)
  );

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: issues a read and queues what the scoreboard must see
  task automatic bus_rd(input int unsigned a, input logic [DATA_W-1:0] e, input string req);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic bus_wr(input int unsigned a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // monitor: pops the scoreboard on every returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("unexpected read data", 1, 0);
      end else begin
        string t;
        logic [DATA_W-1:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 vector", irq_vector, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 rx_pop", rx_pop, 0);
    check("R1 rvalid", bus_rvalid, 0);
    bus_rd('h080, 'h00, "R1 R2 rx status after reset");
    bus_rd('h088, 'h80, "R3 tx status ready");

    // R4 status write, flag bit discarded
    bus_wr('h080, 'hFF);
    bus_rd('h080, 'h7F, "R4 rx control loaded, flag from input");
    check("R8 no irq without char", irq, 0);

    // R8 receive interrupt
    rx_byte = 8'h5A; rx_avail = 1'b1;
    @(negedge clk);
    check("R8 irq", irq, 1);
    check("R8 vector", irq_vector, 8'hF8);
    bus_rd('h080, 'hFF, "R2 rx flag mirrors input");

    // R5 receive data pop
    bus_rd('h084, 'h5A, "R5 rx data");
    check("R5 pop high", rx_pop, 1);
    rx_avail = 1'b0;
    @(negedge clk);
    check("R5 pop one cycle", rx_pop, 0);
    check("R10 sticky after cause gone", irq, 1);
    bus_rd('h084, 'h00, "R5 empty read");
    check("R5 no pop when empty", rx_pop, 0);

    // R10 clear by status write
    bus_wr('h080, 'h00);
    check("R10 cleared", irq, 0);
    @(negedge clk);
    check("R10 stays low", irq, 0);

    // R9 transmit interrupt and priority
    bus_wr('h088, 'hC0);
    bus_rd('h088, 'hC0, "R3 R4 tx status");
    check("R9 irq", irq, 1);
    check("R9 vector", irq_vector, 8'hFC);
    rx_byte = 8'h33; rx_avail = 1'b1;
    bus_wr('h080, 'h40);
    check("R10 clear with tx enabled", irq, 0);
    @(negedge clk);
    check("R9 both set irq", irq, 1);
    check("R9 tx wins", irq_vector, 8'hFC);
    bus_wr('h088, 'h00);
    check("R10 clear by tx status", irq, 0);
    @(negedge clk);
    check("R8 rx vector after tx off", irq_vector, 8'hF8);
    check("R8 irq after tx off", irq, 1);
    bus_wr('h080, 'h00);
    rx_avail = 1'b0;
    @(negedge clk);
    check("R10 final clear", irq, 0);

    // R6 transmit data
    bus_wr('h08C, 'h1A5);
    check("R6 tx_valid", tx_valid, 1);
    check("R6 tx_byte", tx_byte, 8'hA5);
    @(negedge clk);
    check("R6 tx_valid one cycle", tx_valid, 0);
    bus_rd('h08C, 'h00, "R6 tx data reads 0");

    // R7 ident and unmapped offsets
    bus_wr('h080, 'h15);
    bus_rd('h100, 128, "R7 ident");
    bus_rd('h104, 'h00, "R7 unmapped read");
    bus_wr('h104, 'hFF);
    check("R7 no tx strobe", tx_valid, 0);
    check("R7 no irq", irq, 0);
    bus_rd('h080, 'h15, "R7 rx control untouched");
    bus_rd('h088, 'h80, "R7 tx control untouched");

    // R11 receive data writes ignored
    rx_byte = 8'h66; rx_avail = 1'b1;
    bus_wr('h084, 'h77);
    check("R11 no tx strobe", tx_valid, 0);
    check("R11 no pop", rx_pop, 0);
    check("R11 irq unchanged", irq, 0);
    bus_rd('h080, 'h95, "R11 rx control untouched");
    rx_avail = 1'b0;

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule